// File: doc/BRIEF.md
# Write Streaming Mode Detector

This block sits beside a cache's miss path and watches cacheable write misses. When writes arrive back to back at increasing, touching addresses, it concludes that software is streaming a buffer. It first asks the cache to merge partial writes into full lines, and then, once the run is long, to stop placing written lines in the cache at all. Any write that breaks the run sends it back to ordinary allocation.

The miss-queue scheduler queries the block before it issues a partial-line write miss. While the detector is merging writes, each block that was recently written in sequence carries a small hold-off budget. A query against a block with budget left spends one unit and returns a wait time, which gives the rest of the line a chance to arrive. A query against an empty budget abandons the stream and resets the detector. The fill path and the prefetch path read combinational decisions from the current mode.

The mode register is a three-state machine. Its states are ALLOC (code 0), COAL (code 1) and NOALLOC (code 2). It has five transitions. ALLOC goes to COAL when the count passes the lower limit. COAL goes to NOALLOC when it passes the upper limit. Any non-touching write goes from any state back to ALLOC. A query that finds an empty budget goes from COAL or NOALLOC back to ALLOC. In every other case the state holds.

Top module: `wr_stream_mode`

## Requirements
- R1: After reset, `mode_o` is 0 (ALLOC), `coalesce_o` is low and the stored next-expected address is 0.
- R2: A cacheable observed write is contiguous when `obs_addr` equals the next-expected address. After each cacheable write, the next-expected address becomes `obs_addr + obs_size`.
- R3: A contiguous write adds `obs_size` to the running byte count. In ALLOC, the mode becomes COAL only when the new count is strictly greater than `COAL_LIM`.
- R4: In COAL, a contiguous write moves the mode to NOALLOC only when the new count is strictly greater than `NOALLOC_LIM`. NOALLOC is entered only from COAL, and further contiguous writes leave it in NOALLOC.
- R5: A non-contiguous cacheable write sets the mode to ALLOC and reloads the byte count with that write's size.
- R6: A write with `obs_uncache` high changes neither the mode, the count nor the next-expected address.
- R7: `coalesce_o` is high exactly in COAL and NOALLOC. `pf_ok` is low when `coalesce_o` is high and `pf_is_wr` is high, and is high otherwise.
- R8: `fill_alloc` equals `fill_aof` when `fill_whole` is low. When `fill_whole` is high, `fill_alloc` is high unless the mode is NOALLOC.
- R9: A contiguous write loads the hold-off counter of `obs_blk` with `DELAY_THR`. A partial query (`q_vld` high, `q_whole` low) made while coalescing on a block whose counter is nonzero raises `q_hold` and sets `q_cycles` to `LINE_BYTES >> q_size_lg`. The counter drops by one on that edge.
- R10: A partial query made while coalescing on a block whose counter is zero leaves `q_hold` low and returns the mode to ALLOC on the next edge. Any query made while not coalescing has no effect on the counters.
- R11: A whole-line query made while coalescing clears that block's counter and holds nothing. A non-contiguous write clears the counter of its own block.
- R12: The counter table holds `ENTRIES` blocks. A block that is not present reads as zero. A new block replaces the entry that was allocated least recently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_vld | input | 1 | A write miss is observed this cycle |
| obs_addr | input | ADDR_W | Byte address of the observed write |
| obs_size | input | SZ_W | Size of the observed write in bytes |
| obs_blk | input | ADDR_W | Line-aligned block address of the observed write |
| obs_uncache | input | 1 | Observed write is uncacheable |
| pf_is_wr | input | 1 | Request offered to the prefetcher is a write |
| pf_ok | output | 1 | Request may be passed to the prefetcher |
| fill_whole | input | 1 | Fill belongs to a miss that was a whole-line write |
| fill_aof | input | 1 | Fill's own allocate-on-fill flag |
| fill_alloc | output | 1 | Final allocate decision for the fill |
| q_vld | input | 1 | Scheduler queries before issuing a write miss |
| q_blk | input | ADDR_W | Block address of the queried miss |
| q_whole | input | 1 | Queried miss is a whole-line write |
| q_size_lg | input | LG_W | log2 of the queried write size in bytes |
| q_hold | output | 1 | Hold the miss back |
| q_cycles | output | HOLD_W | Hold duration in cycles, 0 when not holding |
| mode_o | output | 2 | Current mode: 0 ALLOC, 1 COAL, 2 NOALLOC |
| coalesce_o | output | 1 | Mode is COAL or NOALLOC |

## Verification
A wrong byte count or next-expected address does not show at once. It shows only at the first threshold crossing that comes too early or too late, so the bench walks runs across both limits one write at a time and places the writes exactly on each limit. A stale or misplaced hold-off counter is just as quiet until a later query returns the wrong hold or resets the mode. For that reason each counter effect (load, decrement, clear, eviction) is followed by a query that exposes it on `q_hold` in the same cycle and on `mode_o` one edge later.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
    typedef enum logic [1:0] {
        WM_ALLOC   = 2'd0,
        WM_COAL    = 2'd1,
        WM_NOALLOC = 2'd2
    } wmode_e;
endpackage

// File: rtl/wsm_mode_fsm.sv
module wsm_mode_fsm
    import wsm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SZ_W        = 7,
    parameter int CNT_W       = 16,
    parameter int COAL_LIM    = 256,
    parameter int NOALLOC_LIM = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_ok,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [SZ_W-1:0]   obs_size,
    input  logic              q_reset,
    output wmode_e            mode_o,
    output logic              contig_o
);
    wmode_e              mode_q, mode_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d, sum;
    logic [ADDR_W-1:0]   nxt_q, nxt_d;

    assign contig_o = (obs_addr == nxt_q);
    assign sum      = cnt_q + CNT_W'(obs_size);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WM_ALLOC;
            cnt_q  <= '0;
            nxt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
            nxt_q  <= nxt_d;
        end
    end

    // next state and count
    always_comb begin
        mode_d = mode_q;
        cnt_d  = cnt_q;
        nxt_d  = nxt_q;
        if (obs_ok) begin
            nxt_d = obs_addr + ADDR_W'(obs_size);
            if (contig_o) begin
                unique case (mode_q)
                    WM_ALLOC: begin
                        cnt_d = sum;
                        if (sum > CNT_W'(COAL_LIM)) mode_d = WM_COAL;
                    end
                    WM_COAL: begin
                        cnt_d = sum;
                        if (sum > CNT_W'(NOALLOC_LIM)) mode_d = WM_NOALLOC;
                    end
                    WM_NOALLOC: ;
                    default: mode_d = WM_ALLOC;
                endcase
            end else begin
                cnt_d  = CNT_W'(obs_size);
                mode_d = WM_ALLOC;
            end
        end else if (q_reset) begin
            mode_d = WM_ALLOC;
            cnt_d  = '0;
            nxt_d  = '0;
        end
    end

    // outputs
    always_comb begin
        mode_o = mode_q;
    end
endmodule

// File: rtl/wsm_delay_tab.sv
module wsm_delay_tab #(
    parameter int ADDR_W    = 32,
    parameter int ENTRIES   = 8,
    parameter int DELAY_THR = 4,
    parameter int DLY_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              o_ld,
    input  logic              o_clr,
    input  logic [ADDR_W-1:0] o_blk,
    input  logic              q_dec,
    input  logic              q_clr,
    input  logic [ADDR_W-1:0] q_blk,
    output logic [DLY_W-1:0]  q_cnt_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ADDR_W-1:0] tag_q [ENTRIES];
    logic [DLY_W-1:0]  cnt_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q, o_hit, q_hit;
    logic [IDX_W-1:0]  ptr_q;
    logic              alloc;

    always_comb begin
        q_cnt_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            o_hit[i] = vld_q[i] && (tag_q[i] == o_blk);
            q_hit[i] = vld_q[i] && (tag_q[i] == q_blk);
            if (q_hit[i]) q_cnt_o = q_cnt_o | cnt_q[i];
        end
    end

    assign alloc = o_ld && (o_hit == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (alloc) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                tag_q[g] <= '0;
                cnt_q[g] <= '0;
            end else if (o_ld && o_hit[g]) begin
                cnt_q[g] <= DLY_W'(DELAY_THR);
            end else if (alloc && (ptr_q == IDX_W'(g))) begin
                vld_q[g] <= 1'b1;
                tag_q[g] <= o_blk;
                cnt_q[g] <= DLY_W'(DELAY_THR);
            end else if (o_clr && o_hit[g]) begin
                cnt_q[g] <= '0;
            end else if (q_clr && q_hit[g]) begin
                cnt_q[g] <= '0;
            end else if (q_dec && q_hit[g] && (cnt_q[g] != '0)) begin
                cnt_q[g] <= cnt_q[g] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wr_stream_mode.sv
module wr_stream_mode
    import wsm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int COAL_LIM    = 256,
    parameter int NOALLOC_LIM = 1024,
    parameter int DELAY_THR   = 4,
    parameter int ENTRIES     = 8,
    parameter int CNT_W       = 16,
    parameter int SZ_W        = $clog2(LINE_BYTES) + 1,
    parameter int LG_W        = $clog2($clog2(LINE_BYTES) + 1),
    parameter int HOLD_W      = $clog2(LINE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_vld,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [SZ_W-1:0]   obs_size,
    input  logic [ADDR_W-1:0] obs_blk,
    input  logic              obs_uncache,
    input  logic              pf_is_wr,
    output logic              pf_ok,
    input  logic              fill_whole,
    input  logic              fill_aof,
    output logic              fill_alloc,
    input  logic              q_vld,
    input  logic [ADDR_W-1:0] q_blk,
    input  logic              q_whole,
    input  logic [LG_W-1:0]   q_size_lg,
    output logic              q_hold,
    output logic [HOLD_W-1:0] q_cycles,
    output logic [1:0]        mode_o,
    output logic              coalesce_o
);
    localparam int DLY_W = (DELAY_THR > 0) ? $clog2(DELAY_THR + 1) : 1;

    wmode_e           mode;
    logic             contig, obs_ok, q_act, q_reset;
    logic [DLY_W-1:0] q_cnt;

    assign obs_ok = obs_vld && !obs_uncache;

    wsm_mode_fsm #(
        .ADDR_W(ADDR_W), .SZ_W(SZ_W), .CNT_W(CNT_W),
        .COAL_LIM(COAL_LIM), .NOALLOC_LIM(NOALLOC_LIM)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .obs_ok(obs_ok), .obs_addr(obs_addr),
        .obs_size(obs_size), .q_reset(q_reset), .mode_o(mode), .contig_o(contig)
    );

    wsm_delay_tab #(
        .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .DELAY_THR(DELAY_THR), .DLY_W(DLY_W)
    ) u_tab (
        .clk(clk), .rst_n(rst_n),
        .o_ld(obs_ok && contig), .o_clr(obs_ok && !contig), .o_blk(obs_blk),
        .q_dec(q_hold), .q_clr(q_vld && coalesce_o && q_whole), .q_blk(q_blk),
        .q_cnt_o(q_cnt)
    );

    always_comb begin
        coalesce_o = (mode != WM_ALLOC);
        mode_o     = mode;
        pf_ok      = !(coalesce_o && pf_is_wr);
        fill_alloc = fill_whole ? (mode != WM_NOALLOC) : fill_aof;
        q_act      = q_vld && coalesce_o && !q_whole;
        q_hold     = q_act && (q_cnt != '0);
        q_reset    = q_act && (q_cnt == '0);
        q_cycles   = q_hold ? (HOLD_W'(LINE_BYTES) >> q_size_lg) : '0;
    end
endmodule

// File: rtl/wsm_chk.sv
module wsm_chk #(
    parameter int HOLD_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              obs_vld,
    input logic              obs_uncache,
    input logic              obs_ok,
    input logic              contig,
    input logic              pf_is_wr,
    input logic              pf_ok,
    input logic              fill_whole,
    input logic              fill_alloc,
    input logic              q_vld,
    input logic              q_whole,
    input logic              q_hold,
    input logic [HOLD_W-1:0] q_cycles,
    input logic [1:0]        mode_o,
    input logic              coalesce_o
);
    // R5
    nonseq_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        obs_ok && !contig |=> mode_o == 2'd0);
    // R6
    uncache_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        obs_vld && obs_uncache && !q_vld |=> $stable(mode_o));
    // R4
    noalloc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> $past(mode_o) == 2'd1);
    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);
    // R8
    fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_whole && mode_o == 2'd2 |-> !fill_alloc);
    // R7
    pf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coalesce_o && pf_is_wr |-> !pf_ok);
    // R9
    hold_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_hold |-> coalesce_o && !q_whole && q_cycles != '0);
    // R10
    zero_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_vld && coalesce_o && !q_whole && !q_hold && !obs_vld |=> mode_o == 2'd0);
endmodule

bind wr_stream_mode wsm_chk #(.HOLD_W(HOLD_W)) u_wsm_chk (
    .clk(clk), .rst_n(rst_n), .obs_vld(obs_vld), .obs_uncache(obs_uncache),
    .obs_ok(obs_ok), .contig(contig), .pf_is_wr(pf_is_wr), .pf_ok(pf_ok),
    .fill_whole(fill_whole), .fill_alloc(fill_alloc), .q_vld(q_vld),
    .q_whole(q_whole), .q_hold(q_hold), .q_cycles(q_cycles),
    .mode_o(mode_o), .coalesce_o(coalesce_o)
);

// File: tb/test_wr_stream_mode.sv
`timescale 1ns/1ps
module test_wr_stream_mode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obs_vld = 1'b0, obs_uncache = 1'b0;
    logic [31:0] obs_addr = '0, obs_blk = '0, q_blk = '0;
    logic [6:0]  obs_size = '0;
    logic        pf_is_wr = 1'b0, pf_ok;
    logic        fill_whole = 1'b0, fill_aof = 1'b0, fill_alloc;
    logic        q_vld = 1'b0, q_whole = 1'b0, q_hold;
    logic [2:0]  q_size_lg = '0;
    logic [6:0]  q_cycles;
    logic [1:0]  mode_o;
    logic        coalesce_o;
    int total = 0, bad = 0;
    int h_s, c_s;

    always #2.5 clk = ~clk;

    wr_stream_mode #(
        .ADDR_W(32), .LINE_BYTES(64), .COAL_LIM(128), .NOALLOC_LIM(256),
        .DELAY_THR(2), .ENTRIES(4), .CNT_W(16)
    ) i_wr_stream_mode (.*);

    // {addr, size, uncache nibble, expected mode nibble}
    localparam logic [47:0] VEC [10] = '{
        48'h00001000_40_0_0, 48'h00001040_40_0_0, 48'h00001080_40_0_1,
        48'h000010C0_40_0_1, 48'h00001100_40_0_2, 48'h00001140_40_0_2,
        48'h00005000_40_1_2, 48'h00001180_08_0_2, 48'h00002000_08_0_0,
        48'h00002008_08_0_0
    };

    task automatic chk(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] s, input logic u);
        @(negedge clk);
        obs_vld = 1'b1; obs_addr = a; obs_size = s[6:0];
        obs_blk = a & ~32'h3F; obs_uncache = u;
        @(negedge clk);
        obs_vld = 1'b0; obs_uncache = 1'b0;
    endtask

    task automatic qry(input logic [31:0] b, input logic [2:0] lg, input logic w);
        @(negedge clk);
        q_vld = 1'b1; q_blk = b; q_size_lg = lg; q_whole = w;
        #1;
        h_s = q_hold; c_s = q_cycles;
        @(negedge clk);
        q_vld = 1'b0; q_whole = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 coalesce", coalesce_o, 0);
        pf_is_wr = 1'b1; #1; chk("R7 pf in alloc", pf_ok, 1); pf_is_wr = 1'b0;

        // R2 R3 R4 R5 R6: vector walk
        foreach (VEC[i]) begin
            wr(VEC[i][47:16], VEC[i][15:8], VEC[i][4]);
            chk($sformatf("R2/R3/R4/R5/R6 vec%0d mode", i), mode_o, int'(VEC[i][1:0]));
            chk($sformatf("R7 vec%0d coalesce", i), coalesce_o, int'(VEC[i][1:0] != 2'd0));
        end

        // R9 R10: load, ignore when not coalescing, hold, decrement, reset
        wr(32'h3000, 64, 0);
        wr(32'h3040, 64, 0);
        qry(32'h3040, 3, 0);
        chk("R10 query ignored in ALLOC", h_s, 0);
        wr(32'h3080, 64, 0);
        chk("R3 coal", mode_o, 1);
        fill_whole = 1'b1; fill_aof = 1'b0; #1;
        chk("R8 whole fill in COAL", fill_alloc, 1);
        qry(32'h3040, 3, 0);
        chk("R9 hold", h_s, 1);
        chk("R9 cycles lg3", c_s, 8);
        qry(32'h3040, 5, 0);
        chk("R9 hold second", h_s, 1);
        chk("R9 cycles lg5", c_s, 2);
        qry(32'h3040, 3, 0);
        chk("R10 zero no hold", h_s, 0);
        chk("R10 cycles zero", c_s, 0);
        chk("R10 reset mode", mode_o, 0);

        // R11 whole-line query clears counter
        wr(32'h6000, 64, 0);
        wr(32'h6040, 64, 0);
        wr(32'h6080, 64, 0);
        qry(32'h6080, 3, 1);
        chk("R11 whole no hold", h_s, 0);
        chk("R11 whole keeps mode", mode_o, 1);
        qry(32'h6080, 3, 0);
        chk("R11 cleared by whole", h_s, 0);
        chk("R11 reset after clear", mode_o, 0);

        // R11 non-contiguous write clears its block
        wr(32'h7000, 64, 0);
        wr(32'h7040, 64, 0);
        wr(32'h7080, 64, 0);
        wr(32'h7040, 64, 0);
        chk("R5 break to alloc", mode_o, 0);
        wr(32'h7080, 64, 0);
        wr(32'h70C0, 64, 0);
        chk("R3 coal again", mode_o, 1);
        qry(32'h7040, 3, 0);
        chk("R11 noncontig cleared", h_s, 0);
        chk("R11 reset mode", mode_o, 0);

        // R12 replacement and miss reads zero
        wr(32'h8000, 64, 0);
        wr(32'h8040, 64, 0);
        wr(32'h8080, 64, 0);
        wr(32'h80C0, 64, 0);
        wr(32'h8100, 64, 0);
        wr(32'h8140, 64, 0);
        chk("R4 noalloc", mode_o, 2);
        fill_whole = 1'b1; fill_aof = 1'b1; #1;
        chk("R8 whole fill in NOALLOC", fill_alloc, 0);
        fill_whole = 1'b0; fill_aof = 1'b1; #1;
        chk("R8 partial fill aof=1", fill_alloc, 1);
        fill_aof = 1'b0; #1;
        chk("R8 partial fill aof=0", fill_alloc, 0);
        pf_is_wr = 1'b1; #1;
        chk("R7 pf write blocked", pf_ok, 0);
        pf_is_wr = 1'b0; #1;
        chk("R7 pf read passes", pf_ok, 1);
        qry(32'h8080, 3, 0);
        chk("R12 survivor holds", h_s, 1);
        chk("R12 survivor mode kept", mode_o, 2);
        qry(32'h8040, 3, 0);
        chk("R12 evicted reads zero", h_s, 0);
        chk("R12 reset after miss", mode_o, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule